// File: doc/BRIEF.md
# Wake-up Event Interrupt Aggregator

This block collects wake-up events from inside and outside the chip into sticky status bits held in four 8-bit status banks. Each status bank has a matching 8-bit enable bank. Any pending event whose enable is set raises a summary power-management status bit. When a master enable is also set, that summary bit drives one system control interrupt pin.

The pin's active level can be programmed. Its drive can be push-pull, or open-drain so that it can share a wired line with other interrupt sources. Two sleep-line inputs are decoded into a sleep-state code. This decode runs beside the interrupt path and has no effect on it. A 4-bit register holds the system interrupt number that the interrupt is routed to.

Software reaches everything through a small local register port. Writes take effect on the clock edge, and reads are combinational. The register map is: status banks 0–3 at addresses 0–3, enable banks 0–3 at addresses 4–7, control at 8, interrupt number at 9 and sleep state at 10.

Top module: `wake_evt_aggr`

## Requirements
- R1: After reset, all status and enable bits are 0 and the control register is 0 (master enable off, active-low, push-pull). The interrupt number is 0. The pin is deasserted: `sci_o`=1 and `sci_oe_o`=1.
- R2: A status bit is sticky. Writing 1 to it at its status address (0–3) clears it, and writing 0 leaves it unchanged. An event on `evt_i[8*b+k]` sets bit k of bank b.
- R3: If an event and a write-1 clear hit the same bit in the same cycle, the bit remains set.
- R4: The summary bit (control bit 1, read-only) is the OR over all banks of status AND enable. It drops by itself once no enabled status bit remains set. Enable banks at addresses 4–7 read back as written.
- R5: The interrupt is active exactly when the master enable (control bit 0) and the summary bit are both 1. It does not depend on `slp_s3_i` or `slp_s5_i`.
- R6: Control bit 2 selects polarity. With 0 the pin is active-low (`sci_o`=0 when active). With 1 the pin is active-high.
- R7: Control bit 3 selects open-drain. In that mode `sci_oe_o` is 1 only while the interrupt is active. In push-pull mode `sci_oe_o` is always 1.
- R8: The sleep code on `sleep_state_o` and in bits [1:0] of address 10 is decoded from the inputs (`slp_s3_i`,`slp_s5_i`) as follows: (1,1) gives 0, working; (0,1) gives 1, S3; (0,0) gives 2, S5; (1,0) gives 3, illegal. The illegal case also sets `sleep_bad_o` and bit 2 of address 10.
- R9: The health-monitor event `hm_evt_i` sets bit 0 of status bank 3, the same bit that `evt_i[24]` sets.
- R10: Address 9 holds a 4-bit interrupt number that drives `irq_num_o`. Its upper read bits are 0, and it changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, bit 8*b+k maps to bank b bit k |
| hm_evt_i | input | 1 | Health-monitor event |
| slp_s3_i | input | 1 | S3 sleep line level |
| slp_s5_i | input | 1 | S5 sleep line level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| sci_o | output | 1 | Interrupt pin value |
| sci_oe_o | output | 1 | Interrupt pin output enable |
| irq_num_o | output | 4 | Routed interrupt number |
| sleep_state_o | output | 2 | Decoded sleep code |
| sleep_bad_o | output | 1 | Illegal sleep combination |

## Verification
Sparse random event vectors are mixed with random writes across all register addresses. This shows whether the summary bit follows status AND enable for every bank, and whether write-1 clears hit only the bits they name. Directed cases put an event and a clear on one bit in the same cycle, which tells event priority apart from clear priority. They also walk all four polarity and drive settings with the interrupt both active and idle, which separates the level logic from the output-enable logic. The sleep lines are swept through all four combinations while an interrupt is pending, which shows that the decode is correct and that the pin does not react to it.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  typedef enum logic [1:0] {
    SLP_WORK = 2'd0,
    SLP_S3   = 2'd1,
    SLP_S5   = 2'd2,
    SLP_BAD  = 2'd3
  } sleep_e;

  typedef struct packed {
    logic od;
    logic pol_high;
    logic pme_en;
  } ctrl_t;
endpackage

// File: rtl/wake_sts_bank.sv
module wake_sts_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_i;  // set beats clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign en_o   = en_q;
  assign pend_o = sts_q & en_q;

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i))); // R2
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(set_i)) == $past(set_i))); // R3
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q)); // R4
endmodule

// File: rtl/wake_sleep_dec.sv
module wake_sleep_dec
  import wake_evt_pkg::*;
(
  input  logic   s3_i,
  input  logic   s5_i,
  output sleep_e state_o,
  output logic   bad_o
);
  always_comb begin
    unique case ({s3_i, s5_i})
      2'b11:   state_o = SLP_WORK;
      2'b01:   state_o = SLP_S3;
      2'b00:   state_o = SLP_S5;
      default: state_o = SLP_BAD;
    endcase
  end
  assign bad_o = (state_o == SLP_BAD);
endmodule

// File: rtl/wake_sci_drv.sv
module wake_sci_drv (
  input  logic active_i,
  input  logic pol_high_i,
  input  logic od_i,
  output logic sci_o,
  output logic sci_oe_o
);
  assign sci_o    = pol_high_i ? active_i : ~active_i;
  assign sci_oe_o = od_i ? active_i : 1'b1;  // open-drain drives only when active
endmodule

// File: rtl/wake_evt_aggr.sv
module wake_evt_aggr
  import wake_evt_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BW     = 8,
  parameter int ADDR_W = 4,
  parameter int IRQ_W  = 4,
  parameter int HM_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB*BW-1:0]  evt_i,
  input  logic              hm_evt_i,
  input  logic              slp_s3_i,
  input  logic              slp_s5_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BW-1:0]     reg_wdata_i,
  output logic [BW-1:0]     reg_rdata_o,
  output logic              sci_o,
  output logic              sci_oe_o,
  output logic [IRQ_W-1:0]  irq_num_o,
  output logic [1:0]        sleep_state_o,
  output logic              sleep_bad_o
);
  localparam int HM_BANK = NB - 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(2 * NB);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(2 * NB + 1);
  localparam logic [ADDR_W-1:0] A_SLEEP = ADDR_W'(2 * NB + 2);

  logic [BW-1:0] sts_w  [NB];
  logic [BW-1:0] en_w   [NB];
  logic [NB-1:0] bank_pend;
  logic          pme_sts;
  ctrl_t         ctrl_q;
  logic [IRQ_W-1:0] irq_q;
  sleep_e        slp_state;
  logic          slp_bad;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BW-1:0] set_v, clr_v, pend_v;
    if (b == HM_BANK) begin : g_hm
      assign set_v = evt_i[b*BW +: BW] | (BW'(hm_evt_i) << HM_BIT);
    end else begin : g_plain
      assign set_v = evt_i[b*BW +: BW];
    end
    assign clr_v = (reg_we_i && reg_addr_i == ADDR_W'(b)) ? reg_wdata_i : '0;
    wake_sts_bank #(.W(BW)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_v),
      .clr_i      (clr_v),
      .en_we_i    (reg_we_i && reg_addr_i == ADDR_W'(NB + b)),
      .en_wdata_i (reg_wdata_i),
      .sts_o      (sts_w[b]),
      .en_o       (en_w[b]),
      .pend_o     (pend_v)
    );
    assign bank_pend[b] = |pend_v;
  end

  assign pme_sts = |bank_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) ctrl_q <= '{od: reg_wdata_i[3], pol_high: reg_wdata_i[2],
                                            pme_en: reg_wdata_i[0]};
      if (reg_addr_i == A_IRQ)  irq_q <= reg_wdata_i[IRQ_W-1:0];
    end
  end

  wake_sleep_dec u_sleep (
    .s3_i    (slp_s3_i),
    .s5_i    (slp_s5_i),
    .state_o (slp_state),
    .bad_o   (slp_bad)
  );

  wake_sci_drv u_sci (
    .active_i   (ctrl_q.pme_en & pme_sts),
    .pol_high_i (ctrl_q.pol_high),
    .od_i       (ctrl_q.od),
    .sci_o      (sci_o),
    .sci_oe_o   (sci_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr_i == ADDR_W'(b))      reg_rdata_o = sts_w[b];
      if (reg_addr_i == ADDR_W'(NB + b)) reg_rdata_o = en_w[b];
    end
    if (reg_addr_i == A_CTRL)
      reg_rdata_o = BW'({ctrl_q.od, ctrl_q.pol_high, pme_sts, ctrl_q.pme_en});
    if (reg_addr_i == A_IRQ)   reg_rdata_o = BW'(irq_q);
    if (reg_addr_i == A_SLEEP) reg_rdata_o = BW'({slp_bad, slp_state});
  end

  assign irq_num_o     = irq_q;
  assign sleep_state_o = slp_state;
  assign sleep_bad_o   = slp_bad;

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q.pme_en && pme_sts) |-> (sci_oe_o == !ctrl_q.od) || (sci_o == !ctrl_q.pol_high)); // R5
  AST_OD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.od && !pme_sts) |-> !sci_oe_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(irq_num_o)); // R10
  AST_NO_PEND_NO_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_pend == '0) |-> !reg_rdata_o[1] || reg_addr_i != A_CTRL); // R4
endmodule

// File: tb/wake_evt_aggr_tb_top.sv
module wake_evt_aggr_tb_top;
  localparam int CLK_P = 10;
  localparam int SEED  = 1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic hm = 1'b0, s3 = 1'b1, s5 = 1'b1, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sci, sci_oe, sbad;
  logic [3:0] irqn;
  logic [1:0] sstate;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_sts [4];
  logic [7:0] m_en  [4];
  logic m_pme_en = 0, m_pol = 0, m_od = 0;
  logic [3:0] m_irq = '0;

  always #(CLK_P/2) clk = ~clk;

  wake_evt_aggr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hm_evt_i(hm),
    .slp_s3_i(s3), .slp_s5_i(s5), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sci_o(sci), .sci_oe_o(sci_oe),
    .irq_num_o(irqn), .sleep_state_o(sstate), .sleep_bad_o(sbad)
  );

  function automatic logic m_sum();
    logic s = 1'b0;
    for (int b = 0; b < 4; b++) s |= |(m_sts[b] & m_en[b]);
    return s;
  endfunction
  function automatic logic m_act();
    return m_pme_en & m_sum();
  endfunction
  function automatic logic m_sci();
    return m_pol ? m_act() : ~m_act();
  endfunction
  function automatic logic m_oe();
    return m_od ? m_act() : 1'b1;
  endfunction
  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a < 4) return m_sts[a];
    if (a < 8) return m_en[a-4];
    if (a == 8) return {4'b0, m_od, m_pol, m_sum(), m_pme_en};
    if (a == 9) return {4'b0, m_irq};
    if (a == 10) return {5'b0, (s3 & ~s5), ({s3, s5} == 2'b11) ? 2'd0 :
                         ({s3, s5} == 2'b01) ? 2'd1 : ({s3, s5} == 2'b00) ? 2'd2 : 2'd3};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string req);
    chk({req, " sci"}, 32'(sci), 32'(m_sci()));
    chk({req, " oe"}, 32'(sci_oe), 32'(m_oe()));
    chk({req, " irq"}, 32'(irqn), 32'(m_irq));
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    we = 1'b0; addr = a; evt = '0; hm = 1'b0;
    #1;
    chk(req, 32'(rdata), 32'(m_read(a)));
  endtask

  task automatic step(input logic [31:0] e, input logic h, input logic w,
                      input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    evt = e; hm = h; we = w; addr = a; wdata = d;
    @(posedge clk);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] set = e[b*8 +: 8];
      if (b == 3) set[0] = set[0] | h;
      if (w && a == 4'(b)) m_sts[b] = (m_sts[b] & ~d) | set;
      else m_sts[b] = m_sts[b] | set;
      if (w && a == 4'(b + 4)) m_en[b] = d;
    end
    if (w && a == 4'd8) begin m_pme_en = d[0]; m_pol = d[2]; m_od = d[3]; end
    if (w && a == 4'd9) m_irq = d[3:0];
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    for (int b = 0; b < 4; b++) begin m_sts[b] = '0; m_en[b] = '0; end
    #(CLK_P * 2 + 2);
    // R1 reset state
    chk("R1 sci", 32'(sci), 32'd1);
    chk("R1 oe", 32'(sci_oe), 32'd1);
    chk("R1 irq", 32'(irqn), 32'd0);
    for (int a = 0; a < 10; a++) rd(4'(a), "R1 reg");
    rst_n = 1'b1;

    // R2/R3 sticky, W1C, event wins
    step(32'h0000_0010, 0, 0, 0, 0);
    step(32'h0, 0, 0, 0, 0);
    rd(0, "R2 sticky");
    step(32'h0, 0, 1, 0, 8'hEF);
    rd(0, "R2 write0 keeps");
    step(32'h0000_0010, 0, 1, 0, 8'h10);
    rd(0, "R3 event wins");
    step(32'h0, 0, 1, 0, 8'h10);
    rd(0, "R2 write1 clears");

    // R9 health event lands in bank 3 bit 0
    step(32'h0, 1, 0, 0, 0);
    rd(3, "R9 hm bit");
    chk("R9 bit0", 32'(rdata), 32'h01);

    // R4/R5 summary and master enable, sleep independence
    step(32'h0, 0, 1, 7, 8'h01);
    rd(8, "R4 summary set");
    chk_pins("R5 master off");
    step(32'h0, 0, 1, 8, 8'h01);
    chk_pins("R5 active low");
    chk("R5 level", 32'(sci), 32'd0);
    for (int c = 0; c < 4; c++) begin
      {s3, s5} = 2'(c);
      #1;
      chk_pins("R5 sleep independent");
      rd(10, "R8 sleep reg");
      chk("R8 bad pin", 32'(sbad), 32'(c == 2));
      chk("R8 code pin", 32'(sstate), 32'(m_read(10) & 8'h3));
    end
    {s3, s5} = 2'b11;
    // R6/R7 polarity and drive with active interrupt
    for (int m = 0; m < 4; m++) begin
      step(32'h0, 0, 1, 8, 8'(1 | (m << 2)));
      chk_pins("R6 R7 active");
    end
    step(32'h0, 0, 1, 3, 8'h01);
    rd(8, "R4 summary auto clear");
    chk_pins("R7 od idle");
    chk("R7 oe released", 32'(sci_oe), 32'd0);

    // R10 interrupt number
    step(32'h0, 0, 1, 9, 8'hFA);
    rd(9, "R10 irq upper zero");
    chk_pins("R10 irq pin");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] e = $urandom & $urandom & $urandom;
      logic w = ($urandom % 3) == 0;
      logic [3:0] a = 4'($urandom % 11);
      logic [7:0] d = 8'($urandom);
      step(e, ($urandom % 8) == 0, w, a, d);
      chk_pins("R4 R5 random");
      if (i % 8 == 0) for (int k = 0; k < 10; k++) rd(4'(k), "R2 R4 random reg");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule